// File: doc/BRIEF.md
# Set/Clear Mode and Error Status Register

This block holds the mode and error state of a serial controller: an enable bit that puts the controller in active mode (1) or configuration mode (0), a host-select bit, and six sticky error flags. Software never writes these bits directly. Instead it writes a command word, and that word carries one clear bit and one set bit for each status bit. Any bit of the command word that is 0 leaves its target unchanged. This lets several bits be changed in one write without a read-modify-write.

Hardware error events from the detection logic also set the error flags. Each event does so only when its matching enable bit from the control word is 1. The error flags stay set until a command clears them. The OR of the flags drives an error interrupt request. A read of the status view shows the mode bits, the flags and a busy indication passed through from the shifter.

Top module: `ctl_status_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable bit, the host-select bit and all six error flags return to 0 after that edge, and `irq_err` is 0.
- R2: A command write with bit 1 set makes status bit 0 (enable) 1, and a write with bit 0 set makes it 0.
- R3: A command write with bit 3 set makes status bit 1 (host select) 1, and bit 2 set makes it 0.
- R4: The command bits set and clear the error flags as follows. Each flag is shown at its status position:
  - transmit error: set 12, clear 8, status 8.
  - receive error: set 13, clear 9, status 9.
  - abort: set 14, clear 10, status 10.
  - transmit underflow: set 15, clear 11, status 11.
  - receive underflow: set 5, clear 4, status 12.
  - mode error: set 7, clear 6, status 7.
  
  Several bits may act in one write.
- R5: When the set bit and the clear bit of the same target are both 1 in one write, that target keeps its value.
- R6: An event on `err_evt[i]` sets its flag only when `err_en[i]` is 1. The index order is 0 transmit error, 1 receive error, 2 abort, 3 transmit underflow, 4 receive underflow, 5 mode error. With the enable at 0, the event has no effect.
- R7: An error flag stays 1 after its event goes away, until a clear command reaches it.
- R8: When an enabled event and a clear command hit the same flag in the same cycle, the flag ends at 1.
- R9: `irq_err` is 1 exactly when at least one of the six error flags is 1.
- R10: Status bit 13 follows `busy_in` in the same cycle. Status bits 2 to 6, 14 and 15 read as 0.
- R11: When `cmd_wr` is 0, `cmd_data` has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Command word with set and clear bit pairs |
| err_en | input | 6 | Error enable bits from the control word |
| err_evt | input | 6 | Hardware error event pulses |
| busy_in | input | 1 | Busy indication from the shifter |
| status_out | output | 16 | Status view |
| irq_err | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is a collision between an enabled hardware event and a clear command on the same flag in the same cycle. The bench produces it by driving the strobe, the clear bit, the event and its enable on one falling edge. It then checks that the flag survives. A second write with the event removed confirms that the clear itself works. Disabled events and strobes held at 0 with arbitrary data are driven between known states, so that any stray change shows in the status view.

// File: rtl/ctl_status_pkg.sv
// Shared encodings for the set/clear status register.
// Assumes a 16-bit command word and a 16-bit status view.
package ctl_status_pkg;
    localparam int NUM_ERR  = 6;
    localparam int NUM_BITS = NUM_ERR + 2;   // enable, host, errors
    localparam int CMD_W    = 16;
    localparam int STAT_W   = 16;

    // Internal bit index: 0 enable, 1 host, 2.. errors in err_idx_e order
    typedef enum int {
        E_TX  = 0,
        E_RX  = 1,
        E_AB  = 2,
        E_TXU = 3,
        E_RXU = 4,
        E_MOD = 5
    } err_idx_e;

    localparam int BUSY_POS = 13;

    // Command bit position that clears internal bit k
    function automatic int clr_pos(input int k);
        case (k)
            0: return 0;
            1: return 2;
            2 + E_TX:  return 8;
            2 + E_RX:  return 9;
            2 + E_AB:  return 10;
            2 + E_TXU: return 11;
            2 + E_RXU: return 4;
            default:   return 6;   // mode error
        endcase
    endfunction

    // Command bit position that sets internal bit k
    function automatic int set_pos(input int k);
        case (k)
            0: return 1;
            1: return 3;
            2 + E_TX:  return 12;
            2 + E_RX:  return 13;
            2 + E_AB:  return 14;
            2 + E_TXU: return 15;
            2 + E_RXU: return 5;
            default:   return 7;
        endcase
    endfunction

    // Status view position of internal bit k
    function automatic int stat_pos(input int k);
        case (k)
            0: return 0;
            1: return 1;
            2 + E_TX:  return 8;
            2 + E_RX:  return 9;
            2 + E_AB:  return 10;
            2 + E_TXU: return 11;
            2 + E_RXU: return 12;
            default:   return 7;
        endcase
    endfunction
endpackage

// File: rtl/ctl_cmd_decode.sv
// Splits a command word into per-bit set and clear requests.
// Assumes the strobe qualifies the data; outputs are zero without it.
module ctl_cmd_decode
    import ctl_status_pkg::*;
(
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_data,
    output logic [NUM_BITS-1:0] set_req,
    output logic [NUM_BITS-1:0] clr_req
);
    // Gather the set/clear bit pair of each target from the command word
    always_comb begin
        for (int k = 0; k < NUM_BITS; k++) begin
            set_req[k] = cmd_wr & cmd_data[set_pos(k)];
            clr_req[k] = cmd_wr & cmd_data[clr_pos(k)];
        end
    end
endmodule

// File: rtl/ctl_sticky_bit.sv
// One status bit with set, clear and hardware event.
// Precedence: event, then a lone set or clear; set with clear holds.
module ctl_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic hw_evt,
    output logic q
);
    // Update the stored bit once per clock
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= 1'b0;
        else if (hw_evt)             q <= 1'b1;
        else if (set_req && !clr_req) q <= 1'b1;
        else if (clr_req && !set_req) q <= 1'b0;
    end

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> q);

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && clr_req && !hw_evt) |=> $stable(q));
endmodule

// File: rtl/ctl_status_pack.sv
// Places the stored bits and busy into the status view.
// Unused status positions read as zero.
module ctl_status_pack
    import ctl_status_pkg::*;
(
    input  logic [NUM_BITS-1:0] bits,
    input  logic                busy,
    output logic [STAT_W-1:0]   stat
);
    // Scatter each bit to its fixed status position
    always_comb begin
        stat = '0;
        for (int k = 0; k < NUM_BITS; k++)
            stat[stat_pos(k)] = bits[k];
        stat[BUSY_POS] = busy;
    end
endmodule

// File: rtl/ctl_status_reg.sv
// Mode and sticky-error status register driven by a set/clear
// command word. Assumes event pulses are synchronous to clk.
module ctl_status_reg
    import ctl_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic [NUM_ERR-1:0] err_en,
    input  logic [NUM_ERR-1:0] err_evt,
    input  logic              busy_in,
    output logic [STAT_W-1:0] status_out,
    output logic              irq_err
);
    logic [NUM_BITS-1:0] set_req, clr_req, evt_vec, bits_q;

    ctl_cmd_decode u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .set_req  (set_req),
        .clr_req  (clr_req)
    );

    // Only enabled events reach the error bits; mode bits have none
    always_comb begin
        evt_vec = '0;
        evt_vec[NUM_BITS-1:2] = err_evt & err_en;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_BITS; g++) begin : g_bit
            ctl_sticky_bit u_bit (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_req (set_req[g]),
                .clr_req (clr_req[g]),
                .hw_evt  (evt_vec[g]),
                .q       (bits_q[g])
            );
        end
    endgenerate

    ctl_status_pack u_pack (
        .bits (bits_q),
        .busy (busy_in),
        .stat (status_out)
    );

    // Interrupt request from any stored error flag
    always_comb irq_err = |bits_q[NUM_BITS-1:2];

    // R9
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == (|{status_out[12:7]}));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && ((err_evt & err_en) == '0)) |=> $stable(status_out[12:0]));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status_out[12:0] == '0 && !irq_err));
endmodule

// File: tb/ctl_status_reg_tb.sv
// Table-driven bench for the set/clear status register.
module ctl_status_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [5:0]  err_en = '0;
    logic [5:0]  err_evt = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status_out;
    logic        irq_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ctl_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .err_en(err_en), .err_evt(err_evt), .busy_in(busy_in),
        .status_out(status_out), .irq_err(irq_err)
    );

    // {wr, cmd, en, evt, busy, exp_status, exp_irq}
    localparam int NV = 22;
    localparam logic [46:0] VEC [NV] = '{
        {1'b1,16'h0002,6'h00,6'h00,1'b0,16'h0001,1'b0}, // R2 set enable
        {1'b1,16'h0008,6'h00,6'h00,1'b0,16'h0003,1'b0}, // R3 set host
        {1'b1,16'h0001,6'h00,6'h00,1'b0,16'h0002,1'b0}, // R2 clear enable
        {1'b1,16'h0003,6'h00,6'h00,1'b0,16'h0002,1'b0}, // R5 pair on enable
        {1'b1,16'h1000,6'h00,6'h00,1'b0,16'h0102,1'b1}, // R4 tx
        {1'b1,16'h2000,6'h00,6'h00,1'b0,16'h0302,1'b1}, // R4 rx
        {1'b1,16'h4000,6'h00,6'h00,1'b0,16'h0702,1'b1}, // R4 abort
        {1'b1,16'h8000,6'h00,6'h00,1'b0,16'h0F02,1'b1}, // R4 tx underflow
        {1'b1,16'h0020,6'h00,6'h00,1'b0,16'h1F02,1'b1}, // R4 rx underflow
        {1'b1,16'h0080,6'h00,6'h00,1'b0,16'h1F82,1'b1}, // R4 mode error
        {1'b1,16'h0F00,6'h00,6'h00,1'b0,16'h1082,1'b1}, // R4 multi clear
        {1'b1,16'h0050,6'h00,6'h00,1'b0,16'h0002,1'b0}, // R9 irq drops
        {1'b0,16'hAAAA,6'h00,6'h00,1'b0,16'h0002,1'b0}, // R11 no strobe
        {1'b0,16'h0000,6'h00,6'h01,1'b0,16'h0002,1'b0}, // R6 disabled evt
        {1'b0,16'h0000,6'h01,6'h01,1'b0,16'h0102,1'b1}, // R6 enabled evt
        {1'b0,16'h0000,6'h01,6'h00,1'b0,16'h0102,1'b1}, // R7 sticky
        {1'b1,16'h0100,6'h01,6'h01,1'b0,16'h0102,1'b1}, // R8 event wins
        {1'b1,16'h0100,6'h01,6'h00,1'b0,16'h0002,1'b0}, // R7 clear
        {1'b0,16'h0000,6'h00,6'h00,1'b1,16'h2002,1'b0}, // R10 busy
        {1'b0,16'h0000,6'h20,6'h20,1'b0,16'h0082,1'b1}, // R6 mode event
        {1'b1,16'h00C0,6'h00,6'h00,1'b0,16'h0082,1'b1}, // R5 pair on flag
        {1'b1,16'h0044,6'h00,6'h00,1'b0,16'h0000,1'b0}  // R3 clear host
    };
    string tags [NV] = '{"R2","R3","R2","R5","R4","R4","R4","R4","R4","R4",
                         "R4","R9","R11","R6","R6","R7","R8","R7","R10","R6",
                         "R5","R3"};

    task automatic check(input string tag, input logic [15:0] es, input logic ei);
        checks++;
        if (status_out !== es || irq_err !== ei) begin
            fails++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     tag, status_out, irq_err, es, ei);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cmd_wr, cmd_data, err_en, err_evt, busy_in} = VEC[i][46:17];
            @(posedge clk); #1;
            cmd_wr = 1'b0; err_evt = '0; busy_in = VEC[i][17];
            #1;
            check(tags[i], VEC[i][16:1], VEC[i][0]);
            busy_in = 1'b0;
        end
        // R10 unused positions stay 0 with every set bit given
        @(negedge clk); cmd_wr = 1'b1; cmd_data = 16'hF0AA;
        @(posedge clk); #1; cmd_wr = 1'b0;
        check("R10", 16'h1F83, 1'b1);
        // R1 reset in mid operation
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", 16'h0000, 1'b0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule